// File: doc/BRIEF.md
# Disk Sector Timing and Gate Controller

This block times sectors for a serial disk-style device controller. It runs on the system clock. A one-cycle strobe, `dev_tick`, marks each device bit clock. The block samples the index-mark and sector-mark inputs on each tick into delayed copies. It also forms a one-cycle pulse when the sector mark rises. From the ticks it derives a byte-clock enable that is high for one device clock out of every eight.

The byte enable and the synchronised marks drive several flags and gates:
- a sector-zero flag;
- a read gate that opens only on a byte boundary inside a sector mark;
- a write gate that needs a steady request and is suppressed by a sector mark;
- a sticky abort flag for a sector mark that arrives while reading;
- a device-select qualifier that arms from a ready device and a sector-mark pulse, and is withdrawn by a drive/head register write.

A small read port returns these bits, one clock after the address is applied. All outputs are registered. A synchronous reset clears every flag, gate and counter.

Top module: `sector_timer`

## Requirements
- R1: After a synchronous reset, every output reads 0: `byte_en`, `sector_zero`, `read_gate`, `write_gate`, `abort_flag`, `sel_ok` and `rd_data`.
- R2: `byte_en` changes only on device ticks. It becomes 1 after the 8th tick following reset, stays 1 until the next tick, and repeats every 8 ticks.
- R3: `sector_zero` becomes 1 on the second tick that finds `index_mark` high, counting from the tick that first samples it (the first tick only synchronises the mark).
- R4: `sector_zero` stays 1 across any number of ticks while both marks are low.
- R5: `sector_zero` clears on the second tick that finds `sector_mark` high. The sector mark wins when both marks are high.
- R6: `read_gate` rises on a tick where three things hold: `rd_req` is 1, the synchronised sector mark is 1, and `byte_en` is 1. From reset, with the mark and request held high, this is the 9th tick.
- R7: Once `rd_req` is 0 and `sector_mark` is 0, `read_gate` falls on the second tick, because the synchronised mark lags the input by one tick.
- R8: `abort_flag` becomes 1 one clock after a sector-mark pulse that occurs while `read_gate` is 1. A sector-mark pulse is the clock after a tick that first samples `sector_mark` high. Once set, `abort_flag` stays 1 until reset.
- R9: With the mark low, `write_gate` rises on the second consecutive tick that sees `wr_req` high, given that `sel_ok` is 1. It falls on the first tick that sees `wr_req` low.
- R10: A synchronised sector mark forces `write_gate` low on the tick after the one that samples the mark, even while `wr_req` is 1.
- R11: `write_gate` is 0 from the second clock after `sel_ok` goes low, whatever the request.
- R12: `sel_ok` rises on the 17th clock edge after a tick that samples a rising `sector_mark` while `ready` is 1. A one-clock `sel_clear` strobe drops it on the next edge.
- R13: The read port returns a value one clock after `rd_addr` is applied. At address 0, bit 0 is `sector_zero`, bit 1 is abort, bit 2 is `sel_ok` and bit 3 is `byte_en`. At address 1, bit 0 is the read gate, bit 1 is the write gate, bit 2 is the synchronised index mark and bit 3 is the synchronised sector mark. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_tick | input | 1 | One-clock strobe per device bit clock |
| index_mark | input | 1 | Index mark from the device |
| sector_mark | input | 1 | Sector mark from the device |
| ready | input | 1 | Device ready |
| rd_req | input | 1 | Read gate request bit |
| wr_req | input | 1 | Write gate request bit |
| sel_clear | input | 1 | Strobe from a drive/head register write |
| rd_addr | input | 1 | Read port address |
| rd_data | output | 8 | Read port data, registered |
| byte_en | output | 1 | Byte-clock enable |
| sector_zero | output | 1 | Sector-zero status flag |
| read_gate | output | 1 | Read gate |
| write_gate | output | 1 | Write gate, masked by select |
| abort_flag | output | 1 | Sticky abort |
| sel_ok | output | 1 | Device-select qualifier |

## Verification
The assertions check four rules on every cycle:
- `byte_en` moves only on ticks;
- the read gate opens only on a byte enable;
- the write gate never outlives `sel_ok` by more than a clock;
- abort is sticky and the select qualifier never rises straight after a clear.

The exact tick counts can only be shown by the bench's scenarios. These cover the first byte enable, the sector-zero set and clear, the read gate rise and fall, the write-gate hold, the 17-edge select delay and the read-port bit positions.

// File: rtl/st_pkg.sv
package st_pkg;
    localparam int RD_W = 8;

    typedef enum logic {
        ADDR_STATUS = 1'b0,
        ADDR_GATES  = 1'b1
    } rd_sel_e;
endpackage

// File: rtl/st_divider.sv
module st_divider #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic byte_en
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          en;
    } div_t;

    div_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.en  = (s_q.cnt == LAST);
            s_d.cnt = (s_q.cnt == LAST) ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign byte_en = s_q.en;
endmodule

// File: rtl/st_mark_sync.sv
module st_mark_sync (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic index_mark,
    input  logic sector_mark,
    output logic idx_dly,
    output logic sm_dly,
    output logic sm_pls
);
    typedef struct packed {
        logic idx;
        logic sm;
        logic pls;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.pls = tick & sector_mark & ~s_q.sm;
        if (tick) begin
            s_d.idx = index_mark;
            s_d.sm  = sector_mark;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign idx_dly = s_q.idx;
    assign sm_dly  = s_q.sm;
    assign sm_pls  = s_q.pls;
endmodule

// File: rtl/st_select.sv
module st_select #(
    parameter int SEL_WAIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ready,
    input  logic sm_pls,
    input  logic sel_clear,
    output logic sel_ok
);
    localparam int SW = (SEL_WAIT > 1) ? $clog2(SEL_WAIT) : 1;
    localparam logic [SW-1:0] LAST = SW'(SEL_WAIT - 1);

    typedef struct packed {
        logic          arm;
        logic [SW-1:0] cnt;
        logic          ok;
    } sel_t;

    sel_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sel_clear) begin
            s_d = '0;
        end else if (s_q.arm) begin
            if (s_q.cnt == LAST) begin
                s_d.ok  = 1'b1;
                s_d.arm = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (ready && sm_pls && !s_q.ok) begin
            s_d.arm = 1'b1;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign sel_ok = s_q.ok;
endmodule

// File: rtl/st_gates.sv
module st_gates #(
    parameter int WR_HOLD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic byte_en,
    input  logic idx_dly,
    input  logic sm_dly,
    input  logic sm_pls,
    input  logic rd_req,
    input  logic wr_req,
    input  logic sel_ok,
    output logic sector_zero,
    output logic read_gate,
    output logic write_gate,
    output logic abort_flag
);
    localparam int HW = $clog2(WR_HOLD + 1);
    localparam logic [HW-1:0] HOLD_TOP = HW'(WR_HOLD - 1);

    typedef struct packed {
        logic          sz;
        logic          rg;
        logic [HW-1:0] wcnt;
        logic          wg_int;
        logic          wg;
        logic          abort;
    } gate_t;

    gate_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.abort = s_q.abort | (s_q.rg & sm_pls);
        if (tick) begin
            if (sm_dly)       s_d.sz = 1'b0;
            else if (idx_dly) s_d.sz = 1'b1;

            if (s_q.rg) begin
                if (!rd_req && !sm_dly) s_d.rg = 1'b0;
            end else if (rd_req && sm_dly && byte_en) begin
                s_d.rg = 1'b1;
            end

            if (sm_dly || !wr_req) begin
                s_d.wcnt   = '0;
                s_d.wg_int = 1'b0;
            end else begin
                s_d.wg_int = (s_q.wcnt >= HOLD_TOP);
                if (s_q.wcnt < HOLD_TOP) s_d.wcnt = s_q.wcnt + 1'b1;
            end
        end
        s_d.wg = s_d.wg_int & sel_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign sector_zero = s_q.sz;
    assign read_gate   = s_q.rg;
    assign write_gate  = s_q.wg;
    assign abort_flag  = s_q.abort;
endmodule

// File: rtl/sector_timer.sv
module sector_timer #(
    parameter int DIV      = 8,
    parameter int SEL_WAIT = 16,
    parameter int WR_HOLD  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dev_tick,
    input  logic                 index_mark,
    input  logic                 sector_mark,
    input  logic                 ready,
    input  logic                 rd_req,
    input  logic                 wr_req,
    input  logic                 sel_clear,
    input  logic                 rd_addr,
    output logic [st_pkg::RD_W-1:0] rd_data,
    output logic                 byte_en,
    output logic                 sector_zero,
    output logic                 read_gate,
    output logic                 write_gate,
    output logic                 abort_flag,
    output logic                 sel_ok
);
    import st_pkg::*;

    logic idx_dly, sm_dly, sm_pls;
    logic [RD_W-1:0] rd_d, rd_q;

    st_divider #(.DIV(DIV)) u_div (
        .clk(clk), .rst(rst), .tick(dev_tick), .byte_en(byte_en)
    );

    st_mark_sync u_sync (
        .clk(clk), .rst(rst), .tick(dev_tick),
        .index_mark(index_mark), .sector_mark(sector_mark),
        .idx_dly(idx_dly), .sm_dly(sm_dly), .sm_pls(sm_pls)
    );

    st_select #(.SEL_WAIT(SEL_WAIT)) u_sel (
        .clk(clk), .rst(rst), .ready(ready), .sm_pls(sm_pls),
        .sel_clear(sel_clear), .sel_ok(sel_ok)
    );

    st_gates #(.WR_HOLD(WR_HOLD)) u_gates (
        .clk(clk), .rst(rst), .tick(dev_tick), .byte_en(byte_en),
        .idx_dly(idx_dly), .sm_dly(sm_dly), .sm_pls(sm_pls),
        .rd_req(rd_req), .wr_req(wr_req), .sel_ok(sel_ok),
        .sector_zero(sector_zero), .read_gate(read_gate),
        .write_gate(write_gate), .abort_flag(abort_flag)
    );

    always_comb begin
        rd_d = '0;
        if (rd_sel_e'(rd_addr) == ADDR_STATUS)
            rd_d[3:0] = {byte_en, sel_ok, abort_flag, sector_zero};
        else
            rd_d[3:0] = {sm_dly, idx_dly, write_gate, read_gate};
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= rd_d;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/st_checker.sv
module st_checker (
    input logic clk,
    input logic rst,
    input logic dev_tick,
    input logic sel_clear,
    input logic byte_en,
    input logic read_gate,
    input logic write_gate,
    input logic abort_flag,
    input logic sel_ok
);
    // R2
    byte_en_tick_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(dev_tick)) |-> $stable(byte_en));

    // R6
    read_gate_on_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(read_gate)) |-> $past(byte_en));

    // R11
    write_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && write_gate) |-> $past(sel_ok));

    // R8
    abort_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        abort_flag |=> abort_flag);

    // R12
    select_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sel_clear |=> !sel_ok);
endmodule

bind sector_timer st_checker u_chk (
    .clk(clk), .rst(rst), .dev_tick(dev_tick), .sel_clear(sel_clear),
    .byte_en(byte_en), .read_gate(read_gate), .write_gate(write_gate),
    .abort_flag(abort_flag), .sel_ok(sel_ok)
);

// File: tb/sim_sector_timer.sv
`timescale 1ns/1ps
module sim_sector_timer;
    logic clk = 1'b0;
    logic rst, dev_tick, index_mark, sector_mark, ready, rd_req, wr_req, sel_clear, rd_addr;
    logic [7:0] rd_data;
    logic byte_en, sector_zero, read_gate, write_gate, abort_flag, sel_ok;
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    sector_timer u0 (
        .clk(clk), .rst(rst), .dev_tick(dev_tick), .index_mark(index_mark),
        .sector_mark(sector_mark), .ready(ready), .rd_req(rd_req), .wr_req(wr_req),
        .sel_clear(sel_clear), .rd_addr(rd_addr), .rd_data(rd_data),
        .byte_en(byte_en), .sector_zero(sector_zero), .read_gate(read_gate),
        .write_gate(write_gate), .abort_flag(abort_flag), .sel_ok(sel_ok)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; dev_tick = 0; index_mark = 0; sector_mark = 0; ready = 0;
        rd_req = 0; wr_req = 0; sel_clear = 0; rd_addr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic dtick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) dev_tick = 1'b1;
            @(negedge clk) dev_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 outputs", {2'b0, byte_en, sector_zero, read_gate, write_gate, abort_flag, sel_ok}, 8'h00);
        chk("R1 rd_data", rd_data, 8'h00);
    endtask

    task automatic t_byte();
        do_reset();
        dtick(7);  chk("R2 before 8th", byte_en, 0);
        dtick(1);  chk("R2 at 8th", byte_en, 1);
        @(negedge clk); chk("R2 held between ticks", byte_en, 1);
        dtick(1);  chk("R2 after 9th", byte_en, 0);
        dtick(6);  chk("R2 at 15th", byte_en, 0);
        dtick(1);  chk("R2 at 16th", byte_en, 1);
    endtask

    task automatic t_sector_zero();
        do_reset();
        index_mark = 1;
        dtick(1); chk("R3 after first tick", sector_zero, 0);
        dtick(1); chk("R3 set", sector_zero, 1);
        @(negedge clk) rd_addr = 0;
        @(negedge clk); chk("R13 status bit0", rd_data[0], 1);
        rd_addr = 1;
        @(negedge clk); chk("R13 gates bits", rd_data, 8'h04);
        index_mark = 0;
        dtick(16); chk("R4 held", sector_zero, 1);
        index_mark = 1; sector_mark = 1;
        dtick(1); chk("R5 after first tick", sector_zero, 1);
        dtick(1); chk("R5 cleared with both marks", sector_zero, 0);
    endtask

    task automatic t_read();
        do_reset();
        sector_mark = 1; rd_req = 1;
        dtick(8); chk("R6 not before byte", read_gate, 0);
        dtick(1); chk("R6 rise", read_gate, 1);
        rd_addr = 1;
        @(negedge clk); chk("R13 gates read", rd_data, 8'h09);
        chk("R8 no abort yet", abort_flag, 0);
        rd_req = 0; sector_mark = 0;
        dtick(1); chk("R7 still open", read_gate, 1);
        dtick(1); chk("R7 fall", read_gate, 0);
    endtask

    task automatic t_abort();
        do_reset();
        sector_mark = 1; rd_req = 1;
        dtick(9);
        sector_mark = 0;
        dtick(1); chk("R8 gate open", read_gate, 1);
        chk("R8 no abort", abort_flag, 0);
        sector_mark = 1;
        dtick(1); chk("R8 abort set", abort_flag, 1);
        rd_req = 0; sector_mark = 0;
        dtick(3); chk("R8 abort sticky", abort_flag, 1);
    endtask

    task automatic t_write();
        do_reset();
        ready = 1; sector_mark = 1;
        dtick(1);
        sector_mark = 0;
        repeat (15) @(negedge clk);
        chk("R12 not at 16th edge", sel_ok, 0);
        @(negedge clk); chk("R12 at 17th edge", sel_ok, 1);
        dtick(1);
        wr_req = 1;
        dtick(1); chk("R9 one tick", write_gate, 0);
        dtick(1); chk("R9 rise", write_gate, 1);
        sector_mark = 1;
        dtick(1); chk("R10 not yet", write_gate, 1);
        dtick(1); chk("R10 forced low", write_gate, 0);
        sector_mark = 0;
        dtick(3); chk("R9 rise again", write_gate, 1);
        wr_req = 0;
        dtick(1); chk("R9 fall", write_gate, 0);
        wr_req = 1;
        dtick(2); chk("R9 reopen", write_gate, 1);
        @(negedge clk) sel_clear = 1;
        @(negedge clk) sel_clear = 0;
        @(negedge clk);
        chk("R12 cleared", sel_ok, 0);
        chk("R11 masked", write_gate, 0);
        dtick(3); chk("R11 stays masked", write_gate, 0);
    endtask

    initial begin
        t_reset();
        t_byte();
        t_sector_zero();
        t_read();
        t_abort();
        t_write();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule